// File: doc/BRIEF.md
# Processor Interrupt and Reset Front End

This block sits between an 8-bit processor core and the external pins for reset, the non-maskable interrupt and the maskable interrupt. All three pins are active low and asynchronous. Each pin passes through a two-stage synchronizer.

The non-maskable pin is edge-detected. A falling edge sets a pending latch, and the latch stays set even after the pin goes high again. The maskable pin is treated as a level.

The core pulses `instr_end` once at the end of every instruction. On that cycle the block looks at both sources and decides whether to start a service. While a service is active it tells the core three things: the restart vector, whether to push the program counter, and whether an acknowledge cycle is in progress. The acknowledge cycle is shown by driving the opcode-fetch and I/O-request indicators low together.

The reset pin is counted before it takes effect. A low pulse counts only once the synchronized pin has been low for `RST_HOLD` consecutive clocks (3 by default). While reset is in force, the bus enables are dropped and every control indicator is held inactive.

The service controller is a three-state machine:
- `ST_RUN`: normal execution.
- `ST_NMI`: non-maskable service.
- `ST_INTA`: maskable acknowledge.

Its transitions are:
- **boundary-nmi**: `ST_RUN` to `ST_NMI`, taken when `instr_end` is high and a non-maskable request is pending.
- **boundary-int**: `ST_RUN` to `ST_INTA`, taken when `instr_end` is high, nothing is pending, the maskable pin is low and the enable flip-flop is set.
- **push-done**: `ST_NMI` or `ST_INTA` back to `ST_RUN`, taken on `push_ack`.
- **reset**: any state to `ST_RUN` while reset is in force.

Top module: `irq_reset_front`

## Requirements
- R1: A falling edge on `nmi_pin_n` that is low for at least one clock sets `nmi_pend`, which stays 1 after the pin returns high.
- R2: A service (`svc_active`=1) begins only in the cycle after an `instr_end` pulse. A pending request never starts a service on its own.
- R3: A pending non-maskable request is serviced when `instr_end` arrives, even if `iff1`=0.
- R4: When both requests are present at the boundary, the non-maskable service is taken.
- R5: During non-maskable service:
  - `push_pc`=1 and `svc_vector`=16'h0066.
  - `ack_m1_n` and `ack_iorq_n` both stay 1, so there is no acknowledge cycle and no vector read from the bus.
- R6: `push_ack` during non-maskable service clears `nmi_pend` and returns the block to `ST_RUN` (`svc_active`=0) at the next clock.
- R7: The maskable pin is honoured at the boundary only when `iff1`=1. Its service drives `ack_m1_n`=0 and `ack_iorq_n`=0 together, with `push_pc`=1 and `svc_vector`=16'h0038.
- R8: The enable flip-flops update as follows:
  - Accepting a non-maskable request copies `iff1` into `iff2` and clears `iff1`.
  - Accepting a maskable request clears both.
  - `ie_restore` copies `iff2` into `iff1`, and `ie_set` sets `iff1`.
- R9: `core_rst` rises only when the synchronized reset pin has stayed low for 3 consecutive clocks. A 2-clock low pulse leaves `core_rst` at 0.
- R10: While `core_rst`=1, the following hold:
  - `addr_oe`=0 and `data_oe`=0.
  - `ack_m1_n`=1 and `ack_iorq_n`=1.
  - `push_pc`=0 and `svc_active`=0.
  - After one clock in reset, `nmi_pend`, `iff1` and `iff2` are 0.
- R11: After the reset pin returns high, `core_rst` falls on the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| nmi_pin_n | input | 1 | Non-maskable interrupt pin, falling-edge sensitive |
| int_pin_n | input | 1 | Maskable interrupt pin, level, active low |
| instr_end | input | 1 | Instruction boundary strobe from the core |
| push_ack | input | 1 | Core has started the program counter push |
| ie_set | input | 1 | Set the interrupt enable flip-flop |
| ie_clr | input | 1 | Clear the interrupt enable flip-flop |
| ie_restore | input | 1 | Copy the saved enable back into iff1 |
| core_rst | output | 1 | Validated reset to the core |
| addr_oe | output | 1 | Address bus drive enable |
| data_oe | output | 1 | Data bus drive enable |
| svc_active | output | 1 | A service action is in progress |
| svc_vector | output | 16 | Restart address for the active service |
| push_pc | output | 1 | Core must push the program counter |
| ack_m1_n | output | 1 | Opcode-fetch indicator, active low |
| ack_iorq_n | output | 1 | I/O request indicator, active low |
| nmi_pend | output | 1 | Non-maskable request is pending |
| iff1 | output | 1 | Interrupt enable flip-flop |
| iff2 | output | 1 | Saved copy of the enable flip-flop |

## Verification
The arbitration is tried with four input patterns:
- A lone one-clock non-maskable pulse, with the enable clear. This separates edge capture and boundary gating from the effect of the enable.
- A held maskable level, first with the enable clear and then with it set. This shows whether masking is applied.
- Both sources present together. This exposes the priority order and the saving of the enable into `iff2`.
- Reset pulses of two and three clocks. These separate the hold threshold by one cycle, and a reset raised during a service shows whether the bus and control outputs are forced idle.

// File: rtl/irf_pkg.sv
package irf_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_NMI  = 2'd1,
        ST_INTA = 2'd2
    } svc_state_t;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_NMI  = 2'd1,
        ACC_INT  = 2'd2
    } accept_t;

    localparam int unsigned DEF_ADDR_W   = 16;
    localparam logic [15:0] DEF_NMI_VEC  = 16'h0066;
    localparam logic [15:0] DEF_INT_VEC  = 16'h0038;
    localparam int unsigned DEF_RST_HOLD = 3;
    localparam int unsigned DEF_SYNC_N   = 2;

endpackage

// File: rtl/irf_sync.sv
module irf_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 1
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    chain[s] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/irf_rst_filter.sv
module irf_rst_filter #(
    parameter int unsigned HOLD = 3
) (
    input  logic clk,
    input  logic pin_low,
    output logic rst_valid
);

    localparam int unsigned CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (!pin_low) begin
            low_cnt <= '0;
        end else if (low_cnt != LIMIT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign rst_valid = (low_cnt == LIMIT);

endmodule

// File: rtl/irf_nmi_latch.sv
module irf_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic line_n,
    input  logic clear,
    output logic pending
);

    logic line_q;
    logic fall;

    always_ff @(posedge clk) begin
        line_q <= line_n;
    end

    assign fall = line_q & ~line_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (fall) begin
            pending <= 1'b1;
        end else if (clear) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/irf_enable_regs.sv
module irf_enable_regs
    import irf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  accept_t accept,
    input  logic    ie_set,
    input  logic    ie_clr,
    input  logic    ie_restore,
    output logic    iff1,
    output logic    iff2
);

    always_ff @(posedge clk) begin
        if (rst) begin
            iff1 <= 1'b0;
            iff2 <= 1'b0;
        end else begin
            unique case (accept)
                ACC_NMI: begin
                    iff2 <= iff1;
                    iff1 <= 1'b0;
                end
                ACC_INT: begin
                    iff1 <= 1'b0;
                    iff2 <= 1'b0;
                end
                default: begin
                    if (ie_clr) begin
                        iff1 <= 1'b0;
                        iff2 <= 1'b0;
                    end else if (ie_set) begin
                        iff1 <= 1'b1;
                        iff2 <= 1'b1;
                    end else if (ie_restore) begin
                        iff1 <= iff2;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/irq_reset_front.sv
module irq_reset_front
    import irf_pkg::*;
#(
    parameter int unsigned        ADDR_W   = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0]  NMI_VEC  = ADDR_W'(DEF_NMI_VEC),
    parameter logic [ADDR_W-1:0]  INT_VEC  = ADDR_W'(DEF_INT_VEC),
    parameter int unsigned        RST_HOLD = DEF_RST_HOLD,
    parameter int unsigned        SYNC_N   = DEF_SYNC_N
) (
    input  logic              clk,
    input  logic              rst_pin_n,
    input  logic              nmi_pin_n,
    input  logic              int_pin_n,
    input  logic              instr_end,
    input  logic              push_ack,
    input  logic              ie_set,
    input  logic              ie_clr,
    input  logic              ie_restore,
    output logic              core_rst,
    output logic              addr_oe,
    output logic              data_oe,
    output logic              svc_active,
    output logic [ADDR_W-1:0] svc_vector,
    output logic              push_pc,
    output logic              ack_m1_n,
    output logic              ack_iorq_n,
    output logic              nmi_pend,
    output logic              iff1,
    output logic              iff2
);

    localparam int unsigned NPIN = 3;
    localparam int unsigned P_RST = 0;
    localparam int unsigned P_NMI = 1;
    localparam int unsigned P_INT = 2;

    logic [NPIN-1:0] pins_async;
    logic [NPIN-1:0] pins_sync;
    logic            rst_v;
    logic            int_req;
    logic            nmi_clear;
    svc_state_t      state_q;
    svc_state_t      state_d;
    accept_t         accept;

    assign pins_async = {int_pin_n, nmi_pin_n, rst_pin_n};

    irf_sync #(
        .STAGES (SYNC_N),
        .WIDTH  (NPIN)
    ) u_sync (
        .clk     (clk),
        .d_async (pins_async),
        .q_sync  (pins_sync)
    );

    irf_rst_filter #(
        .HOLD (RST_HOLD)
    ) u_rst (
        .clk       (clk),
        .pin_low   (~pins_sync[P_RST]),
        .rst_valid (rst_v)
    );

    irf_nmi_latch u_nmi (
        .clk     (clk),
        .rst     (rst_v),
        .line_n  (pins_sync[P_NMI]),
        .clear   (nmi_clear),
        .pending (nmi_pend)
    );

    irf_enable_regs u_ie (
        .clk        (clk),
        .rst        (rst_v),
        .accept     (accept),
        .ie_set     (ie_set),
        .ie_clr     (ie_clr),
        .ie_restore (ie_restore),
        .iff1       (iff1),
        .iff2       (iff2)
    );

    assign int_req   = ~pins_sync[P_INT];
    assign nmi_clear = (state_q == ST_NMI) && push_ack;

    // next-state and acceptance decode
    always_comb begin
        state_d = state_q;
        accept  = ACC_NONE;
        unique case (state_q)
            ST_RUN: begin
                if (instr_end && nmi_pend) begin
                    state_d = ST_NMI;
                    accept  = ACC_NMI;
                end else if (instr_end && int_req && iff1) begin
                    state_d = ST_INTA;
                    accept  = ACC_INT;
                end
            end
            ST_NMI: begin
                if (push_ack) state_d = ST_RUN;
            end
            ST_INTA: begin
                if (push_ack) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
        if (rst_v) begin
            state_d = ST_RUN;
            accept  = ACC_NONE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst_v) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        svc_active = 1'b0;
        svc_vector = '0;
        push_pc    = 1'b0;
        ack_m1_n   = 1'b1;
        ack_iorq_n = 1'b1;
        if (!rst_v) begin
            unique case (state_q)
                ST_NMI: begin
                    svc_active = 1'b1;
                    svc_vector = NMI_VEC;
                    push_pc    = 1'b1;
                end
                ST_INTA: begin
                    svc_active = 1'b1;
                    svc_vector = INT_VEC;
                    push_pc    = 1'b1;
                    ack_m1_n   = 1'b0;
                    ack_iorq_n = 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign core_rst = rst_v;
    assign addr_oe  = ~rst_v;
    assign data_oe  = ~rst_v;

endmodule

// File: rtl/irf_checker.sv
module irf_checker #(
    parameter int unsigned       ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
    parameter logic [ADDR_W-1:0] INT_VEC = 16'h0038
) (
    input logic              clk,
    input logic              instr_end,
    input logic              push_ack,
    input logic              core_rst,
    input logic              addr_oe,
    input logic              data_oe,
    input logic              svc_active,
    input logic [ADDR_W-1:0] svc_vector,
    input logic              push_pc,
    input logic              ack_m1_n,
    input logic              ack_iorq_n,
    input logic              nmi_pend,
    input logic              iff1,
    input logic              iff2
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (core_rst === 1'b1) armed <= 1'b1;
    end

    AST_RST_BUS_IDLE: assert property (@(posedge clk) disable iff (!armed)
        core_rst |-> (!addr_oe && !data_oe && ack_m1_n && ack_iorq_n && !push_pc && !svc_active)); // R10

    AST_RST_STATE_CLEAR: assert property (@(posedge clk) disable iff (!armed)
        (core_rst && $past(core_rst)) |-> (!nmi_pend && !iff1 && !iff2)); // R10

    AST_SVC_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!armed || core_rst)
        $rose(svc_active) |-> $past(instr_end)); // R2

    AST_NMI_NO_ACK_CYCLE: assert property (@(posedge clk) disable iff (!armed || core_rst)
        (svc_active && svc_vector == NMI_VEC) |-> (ack_m1_n && ack_iorq_n && push_pc)); // R5

    AST_INT_ACK_PAIR: assert property (@(posedge clk) disable iff (!armed || core_rst)
        (!ack_iorq_n) |-> (!ack_m1_n && push_pc && svc_vector == INT_VEC)); // R7

    AST_NMI_PRIORITY: assert property (@(posedge clk) disable iff (!armed || core_rst)
        (!svc_active && instr_end && nmi_pend) |=> (core_rst || (svc_vector == NMI_VEC && ack_iorq_n))); // R4

    AST_NMI_IFF_SAVE: assert property (@(posedge clk) disable iff (!armed || core_rst)
        (!svc_active && instr_end && nmi_pend) |=> (core_rst || (!iff1 && iff2 == $past(iff1)))); // R8

    AST_INT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!armed || core_rst)
        $fell(ack_iorq_n) |-> $past(iff1)); // R7

endmodule

bind irq_reset_front irf_checker #(
    .ADDR_W  (ADDR_W),
    .NMI_VEC (NMI_VEC),
    .INT_VEC (INT_VEC)
) u_chk (
    .clk        (clk),
    .instr_end  (instr_end),
    .push_ack   (push_ack),
    .core_rst   (core_rst),
    .addr_oe    (addr_oe),
    .data_oe    (data_oe),
    .svc_active (svc_active),
    .svc_vector (svc_vector),
    .push_pc    (push_pc),
    .ack_m1_n   (ack_m1_n),
    .ack_iorq_n (ack_iorq_n),
    .nmi_pend   (nmi_pend),
    .iff1       (iff1),
    .iff2       (iff2)
);

// File: tb/irq_reset_front_test.sv
module irq_reset_front_test;

    logic        clk = 1'b0;
    logic        rst_pin_n = 1'b1;
    logic        nmi_pin_n = 1'b1;
    logic        int_pin_n = 1'b1;
    logic        instr_end = 1'b0;
    logic        push_ack = 1'b0;
    logic        ie_set = 1'b0;
    logic        ie_clr = 1'b0;
    logic        ie_restore = 1'b0;
    logic        core_rst;
    logic        addr_oe;
    logic        data_oe;
    logic        svc_active;
    logic [15:0] svc_vector;
    logic        push_pc;
    logic        ack_m1_n;
    logic        ack_iorq_n;
    logic        nmi_pend;
    logic        iff1;
    logic        iff2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_reset_front uut (
        .clk        (clk),
        .rst_pin_n  (rst_pin_n),
        .nmi_pin_n  (nmi_pin_n),
        .int_pin_n  (int_pin_n),
        .instr_end  (instr_end),
        .push_ack   (push_ack),
        .ie_set     (ie_set),
        .ie_clr     (ie_clr),
        .ie_restore (ie_restore),
        .core_rst   (core_rst),
        .addr_oe    (addr_oe),
        .data_oe    (data_oe),
        .svc_active (svc_active),
        .svc_vector (svc_vector),
        .push_pc    (push_pc),
        .ack_m1_n   (ack_m1_n),
        .ack_iorq_n (ack_iorq_n),
        .nmi_pend   (nmi_pend),
        .iff1       (iff1),
        .iff2       (iff2)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        tick(1);
        sig = 1'b0;
    endtask

    task automatic nmi_edge();
        nmi_pin_n = 1'b0;
        tick(1);
        nmi_pin_n = 1'b1;
        tick(4);
    endtask

    // R9 R10 R11: full reset with outputs idle, then release timing
    task automatic t_reset();
        rst_pin_n = 1'b0;
        tick(4);
        check("R9", "core_rst before hold", core_rst, 0);
        tick(1);
        check("R9", "core_rst after hold", core_rst, 1);
        tick(2);
        check("R10", "addr_oe", addr_oe, 0);
        check("R10", "data_oe", data_oe, 0);
        check("R10", "ack pair", {ack_m1_n, ack_iorq_n}, 2'b11);
        check("R10", "push/svc", {push_pc, svc_active}, 2'b00);
        check("R10", "pend/iff", {nmi_pend, iff1, iff2}, 3'b000);
        rst_pin_n = 1'b1;
        tick(2);
        check("R11", "core_rst after 2", core_rst, 1);
        tick(1);
        check("R11", "core_rst after 3", core_rst, 0);
        check("R11", "addr_oe back", addr_oe, 1);
    endtask

    // R9: 2-clock pulse ignored
    task automatic t_short_reset();
        int seen = 0;
        rst_pin_n = 1'b0;
        tick(2);
        rst_pin_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (core_rst) seen++;
        end
        check("R9", "2-clock pulse ignored", seen, 0);
        check("R9", "bus kept on", addr_oe, 1);
    endtask

    // R1 R2 R3 R5 R6: lone nmi with enable clear
    task automatic t_nmi_lone();
        check("R3", "iff1 clear before nmi", iff1, 0);
        nmi_edge();
        check("R1", "pending after short pulse", nmi_pend, 1);
        tick(3);
        check("R2", "no service without boundary", svc_active, 0);
        pulse(instr_end);
        check("R3", "service despite iff1=0", svc_active, 1);
        check("R5", "nmi vector", svc_vector, 16'h0066);
        check("R5", "push_pc", push_pc, 1);
        check("R5", "no ack cycle", {ack_m1_n, ack_iorq_n}, 2'b11);
        tick(3);
        check("R6", "held until push_ack", svc_active, 1);
        pulse(push_ack);
        check("R6", "pending cleared", nmi_pend, 0);
        check("R6", "back to run", svc_active, 0);
    endtask

    // R7 R8: maskable masked then honoured
    task automatic t_int();
        int_pin_n = 1'b0;
        tick(3);
        pulse(instr_end);
        check("R7", "masked int ignored", svc_active, 0);
        check("R7", "masked no ack", ack_iorq_n, 1);
        pulse(ie_set);
        check("R8", "ie_set", iff1, 1);
        pulse(instr_end);
        check("R7", "int service", svc_active, 1);
        check("R7", "ack pair low", {ack_m1_n, ack_iorq_n}, 2'b00);
        check("R7", "int vector", svc_vector, 16'h0038);
        check("R7", "int push", push_pc, 1);
        check("R8", "int clears iffs", {iff1, iff2}, 2'b00);
        pulse(push_ack);
        check("R7", "int done", svc_active, 0);
        int_pin_n = 1'b1;
        tick(3);
    endtask

    // R4 R8: both pending, nmi wins; enable saved and restored
    task automatic t_priority();
        pulse(ie_set);
        int_pin_n = 1'b0;
        nmi_edge();
        pulse(instr_end);
        check("R4", "nmi wins vector", svc_vector, 16'h0066);
        check("R4", "nmi wins no ack", ack_iorq_n, 1);
        check("R8", "iff1 cleared iff2 saved", {iff1, iff2}, 2'b01);
        int_pin_n = 1'b1;
        pulse(push_ack);
        check("R6", "idle after push", svc_active, 0);
        tick(3);
        pulse(ie_restore);
        check("R8", "restore iff1", iff1, 1);
    endtask

    // R10: reset during a service
    task automatic t_reset_in_service();
        nmi_edge();
        pulse(instr_end);
        check("R5", "in service", svc_active, 1);
        rst_pin_n = 1'b0;
        tick(5);
        check("R10", "svc dropped in reset", {svc_active, push_pc}, 2'b00);
        check("R10", "bus off in reset", {addr_oe, data_oe}, 2'b00);
        tick(1);
        check("R10", "pend/iff cleared", {nmi_pend, iff1, iff2}, 3'b000);
        rst_pin_n = 1'b1;
        tick(4);
        check("R10", "idle after release", svc_active, 0);
    endtask

    initial begin
        tick(4);
        t_reset();
        t_short_reset();
        t_nmi_lone();
        t_int();
        t_priority();
        t_reset_in_service();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule